// File: doc/BRIEF.md
# Dual-Channel Interval Timer

This peripheral holds two independent 32-bit counters behind a small register bus with a single-cycle write and a combinational read. Each channel has three words at a 16-byte stride: a control/status word, a reload value and the live count. A channel counts up or down once per clock while it is enabled. When it reaches its terminal value it raises a sticky status flag. It can then restart from the reload value, which gives a periodic tick, or it can stop, which gives a one-shot delay.

To use a channel, software writes the reload value and sets the preset bit, which copies that value into the counter on every clock. It then writes the control word with the preset bit cleared and the enable bit set. The status flag is cleared by writing a one to it. Reading the control word and writing the same value back therefore acknowledges a pending event and leaves every other field as it was. One interrupt line is the OR of both channels, each channel gated by its own interrupt-enable bit. The remaining control bits (mode, external output and capture enables, pulse-width mode, global-enable mirror) are stored and read back but change nothing.

Top module: `dual_timer`

## Requirements
- R1: After reset every control bit, every status flag, both reload words and both counters read as zero, and `irq` is low.
- R2: Channel 0 sits at byte offsets 0x00 (control), 0x04 (reload) and 0x08 (count). Channel 1 sits at 0x10, 0x14 and 0x18. Any other offset reads zero, including offsets 0x0C and 0x1C and any offset with a nonzero byte lane. A write to a count word has no effect.
- R3: Control word bits: 0 mode, 1 down (1 = decrement), 2 output enable, 3 capture enable, 4 auto-restart, 5 preset, 6 interrupt enable, 7 run, 8 status, 9 pulse-width enable, 10 global mirror. Stored bits read back as written, bit 8 reads the live flag, and bits 31..11 read zero.
- R4: While the preset bit is 1 the counter takes the reload value on each clock and does not count.
- R5: With run set and preset clear, the counter decrements once per clock when bit 1 is 1 and increments once per clock when bit 1 is 0.
- R6: Terminal count is 0 when counting down and 0xFFFFFFFF when counting up. A running counter at terminal count sets the status flag on the next clock. With auto-restart it loads the reload value on that same clock, so a free-running up-count with reload 0 wraps from 0xFFFFFFFF to 0.
- R7: Without auto-restart, a terminal-count event leaves the counter at terminal count and clears the run bit on the same clock.
- R8: Writing the control word with bit 8 set clears the status flag, and writing it with bit 8 clear leaves the flag unchanged. Writing back the word just read acknowledges the event and keeps the other fields.
- R9: If a status-clearing write and a terminal-count event fall on the same clock, the flag stays set. The run-bit clear of R7 likewise wins over a write that sets run.
- R10: `irq` is high exactly when some channel has both its status flag and its interrupt-enable bit set.
- R11: Clearing run holds the counter at its current value, and the count stays readable.
- R12: The two channels do not affect each other's registers or counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 5 | Byte address of the register word |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
The channels run with a small reload value counting down with auto-restart, which tells the reload distance and the event timing apart from off-by-one errors. A one-shot up-count starts near 0xFFFFFFFF, which separates stopping from wrapping. A reload of zero with auto-restart creates an event on every clock and so forces the collision between an acknowledge write and a new event. A read-then-write-back acknowledge and a write with every bit set exercise field storage and the write-one-to-clear semantics. Every clock, a behavioural model predicts the read data at the current address and the interrupt line and compares them with the design.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DW = 32;

    // Control word bit positions (software-visible layout)
    localparam int B_MODE = 0;
    localparam int B_DOWN = 1;
    localparam int B_OUTE = 2;
    localparam int B_CAPE = 3;
    localparam int B_ARST = 4;
    localparam int B_PRST = 5;
    localparam int B_IE   = 6;
    localparam int B_RUN  = 7;
    localparam int B_STS  = 8;
    localparam int B_PWM  = 9;
    localparam int B_GALL = 10;

    typedef struct packed {
        logic gall;
        logic pwm;
        logic run;
        logic ie;
        logic prst;
        logic arst;
        logic cape;
        logic oute;
        logic down;
        logic mode;
    } ctl_t;

    typedef enum logic [1:0] {
        SEL_CTL  = 2'd0,
        SEL_RELD = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    function automatic logic [DW-1:0] pack_ctl(ctl_t c, logic s);
        logic [DW-1:0] w;
        w         = '0;
        w[B_MODE] = c.mode;
        w[B_DOWN] = c.down;
        w[B_OUTE] = c.oute;
        w[B_CAPE] = c.cape;
        w[B_ARST] = c.arst;
        w[B_PRST] = c.prst;
        w[B_IE]   = c.ie;
        w[B_RUN]  = c.run;
        w[B_STS]  = s;
        w[B_PWM]  = c.pwm;
        w[B_GALL] = c.gall;
        return w;
    endfunction

    function automatic ctl_t unpack_ctl(logic [DW-1:0] w);
        ctl_t c;
        c.mode = w[B_MODE];
        c.down = w[B_DOWN];
        c.oute = w[B_OUTE];
        c.cape = w[B_CAPE];
        c.arst = w[B_ARST];
        c.prst = w[B_PRST];
        c.ie   = w[B_IE];
        c.run  = w[B_RUN];
        c.pwm  = w[B_PWM];
        c.gall = w[B_GALL];
        return c;
    endfunction
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    output logic              hit,
    output logic [ADDR_W-5:0] ch,
    output reg_sel_e          sel,
    output logic [NCH-1:0]    wr_ctl,
    output logic [NCH-1:0]    wr_reld
);
    logic lane_ok;

    // R2: word-aligned, mapped channel, mapped word
    assign lane_ok = (addr[1:0] == 2'b00);
    assign ch      = addr[ADDR_W-1:4];
    assign sel     = reg_sel_e'(addr[3:2]);
    assign hit     = lane_ok && (int'(ch) < NCH) && (sel != SEL_NONE);

    for (genvar g = 0; g < NCH; g++) begin : g_wr
        assign wr_ctl[g]  = wr_en && hit && (int'(ch) == g) && (sel == SEL_CTL);
        assign wr_reld[g] = wr_en && hit && (int'(ch) == g) && (sel == SEL_RELD);
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_ctl,
    input  logic          wr_reld,
    input  logic [DW-1:0] wdata,
    output ctl_t          ctl_o,
    output logic          sts_o,
    output logic [DW-1:0] reld_o,
    output logic [DW-1:0] cnt_o
);
    ctl_t          ctl_q, ctl_n;
    logic          sts_q;
    logic [DW-1:0] reld_q, cnt_q, cnt_n, term;
    logic          active, evt;

    assign term   = ctl_q.down ? '0 : '1;
    assign active = ctl_q.run && !ctl_q.prst;
    assign evt    = active && (cnt_q == term);

    always_comb begin
        ctl_n = wr_ctl ? unpack_ctl(wdata) : ctl_q;
        if (evt && !ctl_q.arst)
            ctl_n.run = 1'b0;               // one-shot stop wins over the write
    end

    always_comb begin
        if (ctl_q.prst)
            cnt_n = reld_q;
        else if (!ctl_q.run)
            cnt_n = cnt_q;
        else if (cnt_q == term)
            cnt_n = ctl_q.arst ? reld_q : cnt_q;
        else if (ctl_q.down)
            cnt_n = cnt_q - 1'b1;
        else
            cnt_n = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            sts_q  <= 1'b0;
            reld_q <= '0;
            cnt_q  <= '0;
        end else begin
            ctl_q  <= ctl_n;
            sts_q  <= evt | (sts_q & ~(wr_ctl & wdata[B_STS]));
            cnt_q  <= cnt_n;
            if (wr_reld)
                reld_q <= wdata;
        end
    end

    assign ctl_o  = ctl_q;
    assign sts_o  = sts_q;
    assign reld_o = reld_q;
    assign cnt_o  = cnt_q;

    // R4
    preset_copy_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_q.prst |=> cnt_q == $past(reld_q));
    // R11
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.run && !ctl_q.prst) |=> $stable(cnt_q));
    // R5
    down_step_chk: assert property (@(posedge clk) disable iff (rst)
        (active && ctl_q.down && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (active && cnt_q == term) |=> sts_q);
    // R7
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !ctl_q.arst && cnt_q == term) |=> (!ctl_q.run && $stable(cnt_q)));
endmodule

// File: rtl/dual_timer.sv
module dual_timer
    import tmr_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     rd_data,
    output logic              irq
);
    localparam int CH_W = ADDR_W - 4;

    logic            hit;
    logic [CH_W-1:0] ch;
    reg_sel_e        sel;
    logic [NCH-1:0]  wr_ctl, wr_reld, sts, req;
    ctl_t            ctl_a  [NCH];
    logic [DW-1:0]   reld_a [NCH];
    logic [DW-1:0]   cnt_a  [NCH];

    tmr_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) i_dec (
        .addr    (addr),
        .wr_en   (wr_en),
        .hit     (hit),
        .ch      (ch),
        .sel     (sel),
        .wr_ctl  (wr_ctl),
        .wr_reld (wr_reld)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_channel i_chan (
            .clk     (clk),
            .rst     (rst),
            .wr_ctl  (wr_ctl[g]),
            .wr_reld (wr_reld[g]),
            .wdata   (wr_data),
            .ctl_o   (ctl_a[g]),
            .sts_o   (sts[g]),
            .reld_o  (reld_a[g]),
            .cnt_o   (cnt_a[g])
        );
        assign req[g] = sts[g] && ctl_a[g].ie;
    end

    // R10
    assign irq = |req;

    // R2, R3
    always_comb begin
        rd_data = '0;
        if (hit) begin
            case (sel)
                SEL_CTL:  rd_data = pack_ctl(ctl_a[ch], sts[ch]);
                SEL_RELD: rd_data = reld_a[ch];
                SEL_CNT:  rd_data = cnt_a[ch];
                default:  rd_data = '0;
            endcase
        end
    end

    // R10
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (sts != '0));
    // R3
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && sel == SEL_CTL) |-> (rd_data[DW-1:B_GALL+1] == '0));
endmodule

// File: tb/test_dual_timer.sv
module test_dual_timer;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  addr;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        irq;

    int    nvec = 0;
    int    nbad = 0;
    bit    done = 1'b0;
    string cur  = "R1";

    always #5 clk = ~clk;

    dual_timer i_dual_timer (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    // Behavioural reference: per channel control bits (bit 8 unused), flag, reload, count
    logic [10:0] m_ctl [2];
    logic        m_sts [2];
    logic [31:0] m_ld  [2];
    logic [31:0] m_cnt [2];

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 2; c++) begin
                m_ctl[c] = '0; m_sts[c] = 0; m_ld[c] = '0; m_cnt[c] = '0;
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                logic [31:0] tc, oc, ol;
                logic [10:0] octl;
                logic ev, wc, wl;
                octl = m_ctl[c]; oc = m_cnt[c]; ol = m_ld[c];
                tc = octl[1] ? 32'h0 : 32'hFFFF_FFFF;
                ev = octl[7] && !octl[5] && (oc == tc);
                wc = wr_en && (addr == 5'(c * 16));
                wl = wr_en && (addr == 5'(c * 16 + 4));
                if (octl[5]) m_cnt[c] = ol;
                else if (octl[7]) begin
                    if (oc == tc) m_cnt[c] = octl[4] ? ol : oc;
                    else m_cnt[c] = octl[1] ? oc - 1 : oc + 1;
                end
                if (wl) m_ld[c] = wr_data;
                if (wc) m_ctl[c] = wr_data[10:0] & 11'h6FF;
                if (ev && !octl[4]) m_ctl[c][7] = 1'b0;
                if (wc && wr_data[8]) m_sts[c] = 1'b0;
                if (ev) m_sts[c] = 1'b1;
            end
        end
    end

    function automatic logic [31:0] mrd(logic [4:0] a);
        int c;
        if (a[1:0] != 0) return '0;
        c = a[4];
        case (a[3:2])
            2'd0: return {21'b0, m_ctl[c][10:9], m_sts[c], m_ctl[c][7:0]};
            2'd1: return m_ld[c];
            2'd2: return m_cnt[c];
            default: return '0;
        endcase
    endfunction

    function automatic logic mirq();
        return (m_sts[0] && m_ctl[0][6]) || (m_sts[1] && m_ctl[1][6]);
    endfunction

    task automatic check();
        logic [31:0] e;
        e = mrd(addr);
        nvec++;
        if (rd_data !== e) begin
            nbad++;
            $display("FAIL %s rd_data addr=%02h actual=%08h expected=%08h", cur, addr, rd_data, e);
        end
        if (irq !== mirq()) begin
            nbad++;
            $display("FAIL %s irq actual=%b expected=%b", cur, irq, mirq());
        end
    endtask

    task automatic cyc(input logic [4:0] a, input logic we, input logic [31:0] d);
        @(negedge clk);
        check();
        addr = a; wr_en = we; wr_data = d;
    endtask

    task automatic idle(input int n, input logic [4:0] a);
        for (int i = 0; i < n; i++) cyc(a, 1'b0, '0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog expired in %s", cur);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; addr = '0; wr_en = 1'b0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset values of all words and irq
        cur = "R1";
        cyc(5'h00, 0, 0); cyc(5'h04, 0, 0); cyc(5'h08, 0, 0);
        cyc(5'h10, 0, 0); cyc(5'h14, 0, 0); cyc(5'h18, 0, 0);
        // R3: field storage, upper bits zero, status write-one with no flag pending
        cur = "R3";
        cyc(5'h00, 1, 32'hFFFF_F71F); idle(2, 5'h00);
        cyc(5'h00, 1, 32'h0);         idle(1, 5'h00);
        // R2: map, unmapped offsets, ignored count writes
        cur = "R2";
        cyc(5'h14, 1, 32'h0000_1234); cyc(5'h08, 1, 32'hDEAD_BEEF);
        cyc(5'h18, 1, 32'h0BAD_F00D);
        idle(1, 5'h14); idle(1, 5'h08); idle(1, 5'h18); idle(1, 5'h0C);
        idle(1, 5'h1C); idle(1, 5'h15); idle(1, 5'h02);
        // R4: preset copies the reload value and holds
        cur = "R4";
        cyc(5'h04, 1, 32'd5); cyc(5'h00, 1, 32'h20); idle(3, 5'h08);
        cyc(5'h04, 1, 32'd4); idle(3, 5'h08);
        // R5/R6/R10: periodic down-count with interrupt enabled
        cur = "R6";
        cyc(5'h00, 1, 32'hD2); idle(14, 5'h08); idle(1, 5'h00);
        // R8: read-then-write-back acknowledge
        cur = "R8";
        cyc(5'h00, 1, mrd(5'h00)); idle(2, 5'h00);
        idle(6, 5'h08);
        cyc(5'h00, 1, mrd(5'h00) & ~32'h100); idle(2, 5'h00);
        cyc(5'h00, 1, mrd(5'h00)); idle(1, 5'h00);
        // R11: stop holds the count
        cur = "R11";
        cyc(5'h00, 1, 32'h100); idle(6, 5'h08);
        // R7: one-shot up-count on channel 1 near the top, R12 channel 0 frozen
        cur = "R7";
        cyc(5'h14, 1, 32'hFFFF_FFFC); cyc(5'h10, 1, 32'h20); idle(2, 5'h18);
        cyc(5'h10, 1, 32'hC0); idle(8, 5'h18); idle(1, 5'h10);
        cur = "R12";
        idle(2, 5'h08); idle(1, 5'h00);
        cyc(5'h10, 1, 32'h100); idle(1, 5'h10);
        // R9: reload 0 with auto-restart gives an event every clock
        cur = "R9";
        cyc(5'h04, 1, 32'h0); cyc(5'h00, 1, 32'h20); idle(1, 5'h08);
        cyc(5'h00, 1, 32'h92); idle(3, 5'h00);
        cyc(5'h00, 1, 32'h192); idle(1, 5'h00);
        cyc(5'h00, 1, 32'h100); idle(1, 5'h00);
        cyc(5'h00, 1, 32'h100); idle(2, 5'h00);
        // R10: flag pending but interrupt disabled keeps irq low
        cur = "R10";
        cyc(5'h00, 1, 32'h82); idle(2, 5'h00);
        cyc(5'h00, 1, 32'h0);  idle(1, 5'h00);
        cyc(5'h00, 1, 32'h40); idle(1, 5'h00);
        cyc(5'h00, 1, 32'h100); idle(1, 5'h00);
        // R9: one-shot stop wins over a write that sets run
        cur = "R9";
        cyc(5'h04, 1, 32'h0); cyc(5'h00, 1, 32'h20); idle(1, 5'h00);
        cyc(5'h00, 1, 32'h82); cyc(5'h00, 1, 32'h82); idle(2, 5'h00);
        // R6: free-running up-count wraps through the reload of zero, R12 meanwhile
        cur = "R6";
        cyc(5'h14, 1, 32'hFFFF_FFFD); cyc(5'h10, 1, 32'h20); idle(1, 5'h18);
        cyc(5'h14, 1, 32'h0); cyc(5'h10, 1, 32'h90); idle(8, 5'h18);
        cur = "R12";
        idle(2, 5'h08); idle(1, 5'h10);
        // R1: reset in the middle of activity
        cur = "R1";
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        idle(1, 5'h00); idle(1, 5'h10); idle(1, 5'h18); idle(1, 5'h04);
        @(negedge clk);
        check();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule